// File: doc/BRIEF.md
# One-Time PROM Programming Controller

This block holds the control register that moves a one-time-programmable byte array between normal reads and programming. When the latch bit is set, a CPU write aimed at the array does not change it. The block captures the address and data of that write instead. When the program-enable bit is then raised, the captured data is burned into the addressed cell. Burning can only clear bits, and an erased cell reads as all ones.

Interlocks govern the two control bits. A high-voltage-detect input gates the setting of the latch bit. A latch bit owned by a neighbouring EEPROM controller cancels this block's latch. In special modes, three test selects become available. The first burns a pair of bytes that differ only in address bit 5. The second switches the array to a bank of extra columns. The third switches it to a bank of extra rows. A saturating counter reports when the program pulse has lasted a minimum number of clocks.

The array is a behavioural model, so the whole programming flow can be checked at the ports. The CPU side is a plain synchronous strobe interface. Register and array reads return one clock after the request.

Top module: `otp_prog_ctrl`

## Requirements
- R1: While the latch bit (register bit 5) is 1 and `ee_latch` is 0, an array write captures its address and data and leaves the array unchanged. Array reads in that state return `arr_rvalid`=0. Otherwise a read returns `arr_rvalid`=1 one clock later, with `arr_rdata` holding the addressed cell.
- R2: A register write does not change the latch bit while the program-enable bit (register bit 0) is 1.
- R3: The program-enable bit changes only on a register write where the latch bit is 1 both before and after that write.
- R4: While `ee_latch` is 1, the latch bit has no effect. No address or data is captured, reads are served, and no cell is burned.
- R5: While the latch bit is effective, program-enable is 1 and a capture is held, the captured data is ANDed into the addressed cell on every clock. Cells start at all ones, and array writes without the latch bit never change a cell.
- R6: When the multi-byte bit (register bit 7) is active, address bit 5 is a don't-care while burning. Both bytes that differ only in bit 5 receive the data. This bit is written only when `special_mode`=1, and it reads 0 and has no effect when `special_mode`=0.
- R7: While `hv_ok` is 0, a write cannot set the latch bit from 0 to 1.
- R8: The extra-column bit (register bit 4) routes reads and burns to a separate bank indexed by address bits 11:5. The extra-row bit (register bit 3), when the column bit is clear, routes them to a bank indexed by bits 5:0. Both bits are written only in special mode, and they read 0 and act as 0 outside it.
- R9: `pgm_done` rises once program-enable has been 1 for PULSE_CYCLES clocks. It clears one clock after program-enable falls.
- R10: Once the latch bit is 0, the captured address and data are discarded. Setting latch and program-enable again without a new array write burns nothing.
- R11: After reset the register reads 0x00 and the outputs are inactive. The register view reaches `reg_rdata` one clock after the state changes, and bits 6, 2 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 when the device runs in a special (test or boot) mode |
| hv_ok | input | 1 | Programming voltage detected |
| ee_latch | input | 1 | Latch bit of the neighbouring EEPROM controller |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Registered control register view |
| arr_re | input | 1 | Array read strobe |
| arr_we | input | 1 | Array write strobe |
| arr_addr | input | ADDR_W | Array byte address |
| arr_wdata | input | DATA_W | Array write data |
| arr_rdata | output | DATA_W | Array read data, valid with arr_rvalid |
| arr_rvalid | output | 1 | Read was served |
| pgm_done | output | 1 | Program pulse has reached its minimum length |

## Verification
The assertions assume that every input is synchronous to `clk` and is sampled only at the rising edge. A level on `hv_ok` or `special_mode` therefore counts only where an edge sees it. The stimulus changes every input on the falling edge and never during reset. `hv_ok` and `special_mode` are moved only between register writes, so every edge that decides a bit sees one stable level. Burns are held far longer than one clock, which lets the multi-byte pair complete before program-enable falls.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_MULTI = 7;
  localparam int BIT_LATCH = 5;
  localparam int BIT_XCOL  = 4;
  localparam int BIT_XROW  = 3;
  localparam int BIT_PGM   = 0;
  localparam int N_SPACES  = 3;

  typedef enum logic [1:0] {
    SPACE_MAIN = 2'd0,
    SPACE_XCOL = 2'd1,
    SPACE_XROW = 2'd2
  } space_e;

  typedef struct packed {
    logic multi;
    logic latch;
    logic xcol;
    logic xrow;
    logic pgm;
  } ctrl_t;
endpackage

// File: rtl/otp_ctrl_reg.sv
module otp_ctrl_reg
  import otp_prog_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             hv_ok,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output ctrl_t            ctrl_q,
  output logic [REG_W-1:0] reg_rdata
);
  logic             latch_n;
  logic [REG_W-1:0] view;

  // latch bit frozen while burning; setting needs the voltage detect
  always_comb begin
    latch_n = ctrl_q.latch;
    if (reg_we && !ctrl_q.pgm) begin
      if (!reg_wdata[BIT_LATCH])
        latch_n = 1'b0;
      else if (!ctrl_q.latch)
        latch_n = hv_ok;
    end
  end

  always_comb begin
    view            = '0;
    view[BIT_MULTI] = ctrl_q.multi & special_mode;
    view[BIT_LATCH] = ctrl_q.latch;
    view[BIT_XCOL]  = ctrl_q.xcol & special_mode;
    view[BIT_XROW]  = ctrl_q.xrow & special_mode;
    view[BIT_PGM]   = ctrl_q.pgm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      reg_rdata <= view;
      if (reg_we) begin
        ctrl_q.latch <= latch_n;
        if (ctrl_q.latch && latch_n)
          ctrl_q.pgm <= reg_wdata[BIT_PGM];
        if (special_mode) begin
          ctrl_q.multi <= reg_wdata[BIT_MULTI];
          ctrl_q.xcol  <= reg_wdata[BIT_XCOL];
          ctrl_q.xrow  <= reg_wdata[BIT_XROW];
        end
      end
    end
  end
endmodule

// File: rtl/otp_bank.sv
module otp_bank #(
  parameter int IDX_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // burning only clears bits
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= mem[wr_idx] & wr_data;
    rd_word <= mem[rd_idx];
  end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              rd_block,
  input  logic [ADDR_W-1:0] rd_addr,
  input  space_e            rd_space,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  space_e            wr_space,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int XCOL_LSB = 5;
  localparam int XCOL_W   = ADDR_W - XCOL_LSB;
  localparam int XROW_W   = 6;

  logic [DATA_W-1:0] words [4];
  space_e            space_q;

  assign words[3] = '0;

  for (genvar g = 0; g < N_SPACES; g++) begin : g_bank
    localparam int IW  = (g == 0) ? ADDR_W : ((g == 1) ? XCOL_W : XROW_W);
    localparam int LSB = (g == 1) ? XCOL_LSB : 0;
    logic we;
    assign we = wr_en && (wr_space == space_e'(g));
    otp_bank #(.IDX_W(IW), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .wr_en   (we),
      .wr_idx  (wr_addr[LSB +: IW]),
      .wr_data (wr_data),
      .rd_idx  (rd_addr[LSB +: IW]),
      .rd_word (words[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      space_q  <= SPACE_MAIN;
    end else begin
      rd_valid <= rd_req && !rd_block;
      space_q  <= rd_space;
    end
  end

  assign rd_data = words[space_q];
endmodule

// File: rtl/otp_pulse_timer.sv
module otp_pulse_timer #(
  parameter int PULSE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      if (cnt != TOP) cnt <= cnt + 1'b1;
      done <= (cnt >= LAST);
    end
  end
endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              special_mode,
  input  logic              hv_ok,
  input  logic              ee_latch,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              arr_re,
  input  logic              arr_we,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_wdata,
  output logic [DATA_W-1:0] arr_rdata,
  output logic              arr_rvalid,
  output logic              pgm_done
);
  localparam int PAIR_BIT = 5;

  ctrl_t             ctrl_q;
  logic              latch_bit, pgm_bit;
  logic              latch_eff, prog_act, phase_q;
  logic              lat_vld;
  logic [ADDR_W-1:0] lat_addr, wr_addr;
  logic [DATA_W-1:0] lat_data;
  space_e            space;

  otp_ctrl_reg u_reg (
    .clk          (clk),
    .rst          (rst),
    .special_mode (special_mode),
    .hv_ok        (hv_ok),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .ctrl_q       (ctrl_q),
    .reg_rdata    (reg_rdata)
  );

  assign latch_bit = ctrl_q.latch;
  assign pgm_bit   = ctrl_q.pgm;
  assign latch_eff = ctrl_q.latch & ~ee_latch;
  assign prog_act  = latch_eff & ctrl_q.pgm & lat_vld;

  always_comb begin
    if (ctrl_q.xcol && special_mode)      space = SPACE_XCOL;
    else if (ctrl_q.xrow && special_mode) space = SPACE_XROW;
    else                                  space = SPACE_MAIN;
  end

  always_comb begin
    wr_addr = lat_addr;
    if (ctrl_q.multi && special_mode) wr_addr[PAIR_BIT] = phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl_q.latch) begin
      lat_vld  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '1;
    end else if (latch_eff && arr_we) begin
      lat_vld  <= 1'b1;
      lat_addr <= arr_addr;
      lat_data <= arr_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !prog_act) phase_q <= 1'b0;
    else                  phase_q <= ~phase_q;
  end

  otp_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (arr_re),
    .rd_block (latch_eff),
    .rd_addr  (arr_addr),
    .rd_space (space),
    .wr_en    (prog_act),
    .wr_addr  (wr_addr),
    .wr_space (space),
    .wr_data  (lat_data),
    .rd_data  (arr_rdata),
    .rd_valid (arr_rvalid)
  );

  otp_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (ctrl_q.pgm),
    .done (pgm_done)
  );
endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       special_mode,
  input logic       hv_ok,
  input logic       ee_latch,
  input logic       arr_re,
  input logic       arr_rvalid,
  input logic [7:0] reg_rdata,
  input logic       pgm_done,
  input logic       latch_q,
  input logic       pgm_q,
  input logic       lat_vld
);
  AST_RD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (arr_re && latch_q && !ee_latch) |=> !arr_rvalid); // R1

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    pgm_q |=> $stable(latch_q)); // R2

  AST_PGM_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $rose(pgm_q) |-> ($past(latch_q) && latch_q)); // R3

  AST_TEST_BITS_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    !$past(special_mode) |-> (reg_rdata[7] == 1'b0)); // R6

  AST_LATCH_NEEDS_HV: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> $past(hv_ok)); // R7

  AST_XSEL_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    !$past(special_mode) |-> (reg_rdata[4:3] == 2'b00)); // R8

  AST_DONE_IN_PGM: assert property (@(posedge clk) disable iff (rst)
    pgm_done |-> $past(pgm_q)); // R9

  AST_CAPTURE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_q) |=> !lat_vld); // R10
endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .special_mode (special_mode),
  .hv_ok        (hv_ok),
  .ee_latch     (ee_latch),
  .arr_re       (arr_re),
  .arr_rvalid   (arr_rvalid),
  .reg_rdata    (reg_rdata),
  .pgm_done     (pgm_done),
  .latch_q      (latch_bit),
  .pgm_q        (pgm_bit),
  .lat_vld      (lat_vld)
);

// File: tb/tb_otp_prog_ctrl.sv
module tb_otp_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 8;
  localparam int NP = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          special_mode = 1'b0, hv_ok = 1'b1, ee_latch = 1'b0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          arr_re = 1'b0, arr_we = 1'b0;
  logic [AW-1:0] arr_addr = '0;
  logic [DW-1:0] arr_wdata = '0;
  logic [DW-1:0] arr_rdata;
  logic          arr_rvalid, pgm_done;

  otp_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYCLES(NP)) dut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .hv_ok(hv_ok),
    .ee_latch(ee_latch), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .arr_re(arr_re), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
    .arr_rvalid(arr_rvalid), .pgm_done(pgm_done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [7:0] mm [3][int];
  bit       m_latch, m_pgm, m_multi, m_xcol, m_xrow;
  bit       m_lvld, m_phase, m_rvalid, m_done, armed;
  int       m_laddr, m_cnt;
  bit [7:0] m_ldata, m_rdata, m_view;

  function automatic int idx_of(int sp, int a);
    if (sp == 1) return (a >> 5) & 8'h7f;
    if (sp == 2) return a & 8'h3f;
    return a;
  endfunction

  function automatic bit [7:0] peek(int sp, int i);
    if (mm[sp].exists(i)) return mm[sp][i];
    return 8'hff;
  endfunction

  always @(posedge clk) begin : model
    bit le, me, xc, xr, burn, nl;
    int sp, a;
    armed = 1'b1;
    if (rst) begin
      m_latch = 0; m_pgm = 0; m_multi = 0; m_xcol = 0; m_xrow = 0;
      m_lvld = 0; m_phase = 0; m_rvalid = 0; m_done = 0; m_cnt = 0;
      m_view = 0; m_laddr = 0; m_ldata = 8'hff;
    end else begin
      le = m_latch && !ee_latch;
      me = m_multi && special_mode;
      xc = m_xcol && special_mode;
      xr = m_xrow && special_mode;
      sp = xc ? 1 : (xr ? 2 : 0);
      burn = le && m_pgm && m_lvld;
      m_rvalid = arr_re && !le;
      if (arr_re) m_rdata = peek(sp, idx_of(sp, int'(arr_addr)));
      if (burn) begin
        a = m_laddr;
        if (me) a = m_phase ? (a | 32'h20) : (a & ~32'h20);
        mm[sp][idx_of(sp, a)] = peek(sp, idx_of(sp, a)) & m_ldata;
      end
      m_phase = burn ? !m_phase : 1'b0;
      if (!m_latch) m_lvld = 0;
      else if (le && arr_we) begin
        m_lvld = 1; m_laddr = int'(arr_addr); m_ldata = arr_wdata;
      end
      if (!m_pgm) begin m_cnt = 0; m_done = 0; end
      else begin
        m_done = (m_cnt >= NP - 1);
        if (m_cnt < NP) m_cnt++;
      end
      m_view = {me, 1'b0, m_latch, xc, xr, 3'b000, m_pgm} >> 0;
      m_view = {me, 1'b0, m_latch, xc, xr, 2'b00, m_pgm};
      if (reg_we) begin
        nl = m_latch;
        if (!m_pgm) begin
          if (!reg_wdata[5]) nl = 0;
          else if (!m_latch) nl = hv_ok;
        end
        if (m_latch && nl) m_pgm = reg_wdata[0];
        m_latch = nl;
        if (special_mode) begin
          m_multi = reg_wdata[7]; m_xcol = reg_wdata[4]; m_xrow = reg_wdata[3];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed && !rst) begin
      chk(reg_rdata == m_view, "R11 register view vs model", reg_rdata, m_view);
      chk(arr_rvalid == m_rvalid, "R1 read valid vs model", arr_rvalid, m_rvalid);
      if (m_rvalid) chk(arr_rdata == m_rdata, "R5 read data vs model", arr_rdata, m_rdata);
      chk(pgm_done == m_done, "R9 pulse flag vs model", pgm_done, m_done);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] exp, input string tag);
    tick();
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic awrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    arr_we = 1'b1; arr_addr = a; arr_wdata = d;
    tick();
    arr_we = 1'b0;
  endtask

  task automatic aread(input logic [AW-1:0] a, input bit exp_v,
                       input logic [DW-1:0] exp, input string tag);
    arr_re = 1'b1; arr_addr = a;
    tick();
    arr_re = 1'b0;
    chk(arr_rvalid == exp_v, tag, arr_rvalid, exp_v);
    if (exp_v) chk(arr_rdata == exp, tag, arr_rdata, exp);
  endtask

  task automatic burn(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [7:0] mode);
    wreg(mode | 8'h20);
    awrite(a, d);
    wreg(mode | 8'h21);
    tick(NP + 2);
    wreg(mode | 8'h20);
    wreg(mode);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL R11 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    chk(reg_rdata == 8'h00, "R11 reset register", reg_rdata, 0);
    chk(arr_rvalid == 1'b0, "R11 reset rvalid", arr_rvalid, 0);
    chk(pgm_done == 1'b0, "R11 reset pulse flag", pgm_done, 0);

    // erased cell, plain write ignored
    aread(12'h123, 1, 8'hff, "R5 erased cell");
    awrite(12'h123, 8'h00);
    aread(12'h123, 1, 8'hff, "R5 write without latch");

    // capture, blocked read, burn, pulse flag, latch interlock
    wreg(8'h20);
    expect_reg(8'h20, "R11 latch readback");
    awrite(12'h123, 8'h5a);
    aread(12'h123, 0, 8'h00, "R1 read blocked in latch");
    wreg(8'h21);
    chk(pgm_done == 1'b0, "R9 flag not early", pgm_done, 0);
    wreg(8'h01);
    expect_reg(8'h21, "R2 latch held while burning");
    tick(NP);
    chk(pgm_done == 1'b1, "R9 flag after pulse", pgm_done, 1);
    wreg(8'h20);
    tick();
    chk(pgm_done == 1'b0, "R9 flag clears", pgm_done, 0);
    wreg(8'h00);
    aread(12'h123, 1, 8'h5a, "R5 burned value");

    // program-enable without latch
    wreg(8'h01);
    expect_reg(8'h00, "R3 pgm without latch");

    // voltage detect
    hv_ok = 1'b0;
    wreg(8'h20);
    expect_reg(8'h00, "R7 latch blocked by hv_ok");
    hv_ok = 1'b1;

    // capture discarded when latch clears
    wreg(8'h20);
    awrite(12'h200, 8'h0f);
    wreg(8'h00);
    tick();
    wreg(8'h20);
    wreg(8'h21);
    tick(5);
    wreg(8'h20);
    wreg(8'h00);
    aread(12'h200, 1, 8'hff, "R10 capture discarded");

    // neighbour latch cancels
    ee_latch = 1'b1;
    wreg(8'h20);
    awrite(12'h300, 8'h00);
    aread(12'h300, 1, 8'hff, "R4 read served under ee_latch");
    wreg(8'h21);
    tick(5);
    wreg(8'h20);
    wreg(8'h00);
    ee_latch = 1'b0;
    aread(12'h300, 1, 8'hff, "R4 nothing burned");

    // multi-byte
    wreg(8'ha0);
    expect_reg(8'h20, "R6 multi ignored in normal mode");
    wreg(8'h00);
    special_mode = 1'b1;
    wreg(8'ha0);
    expect_reg(8'ha0, "R6 multi readback in special");
    wreg(8'h00);
    burn(12'h041, 8'h33, 8'h80);
    aread(12'h041, 1, 8'h33, "R6 pair low byte");
    aread(12'h061, 1, 8'h33, "R6 pair high byte");
    aread(12'h001, 1, 8'hff, "R6 other byte untouched");

    // extra columns and rows
    burn(12'h7e3, 8'hc3, 8'h10);
    wreg(8'h10);
    aread(12'h7e0, 1, 8'hc3, "R8 extra column bank");
    wreg(8'h00);
    aread(12'h7e3, 1, 8'hff, "R8 main untouched by column burn");
    burn(12'hfc5, 8'h3c, 8'h08);
    wreg(8'h08);
    aread(12'h005, 1, 8'h3c, "R8 extra row bank");
    special_mode = 1'b0;
    expect_reg(8'h00, "R8 selects hidden in normal mode");
    aread(12'h005, 1, 8'hff, "R8 selects inactive in normal mode");

    tick(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule